// File: doc/BRIEF.md
# Fault-Triggered Extremum Capture Unit

This unit sits beside a timer counter and samples the running count when a fault event pulse arrives. What it does with the sample depends on a capture mode. It can store every sample. It can keep the lowest or the highest sample seen so far. It can also store every sample and flag a turning point in the series of samples. The unit holds a capture register that software can preload, and it issues a one-cycle flag pulse that an interrupt controller or event router can use.

The fault event is a single-cycle pulse and the unit accepts one in every cycle, so the edge has no valid/ready handshake and no back-pressure. An event that is not taken on the cycle it occurs is lost. All pins are plain control and data levels.

Software can turn the running-minimum mode off by preloading zero into the capture register. It can turn the running-maximum mode off by preloading the counter top value.

Top module: `fault_capture_unit`

## Requirements
- R1: While reset is low, and after it rises, the capture register reads 0 and the flag reads 0.
- R2: In mode 1 (plain capture), every event stores the count and raises the flag.
- R3: In mode 2 (running minimum), an event stores the count only when the count is below the register value. The flag rises only when a store happens. In every other case the register keeps its value.
- R4: In mode 3 (running maximum), an event stores the count only when the count is above the register value. The flag rises only when a store happens. In every other case the register keeps its value.
- R5: In mode 2 with the register at 0, and in mode 3 with the register equal to the top input, events change nothing and raise no flag. This holds even when the count is above top.
- R6: In mode 4 (local minimum), every event stores the count. The flag rises when the new count is greater than or equal to the count of the previous event.
- R7: In mode 5 (local maximum), every event stores the count. The flag rises when the new count is less than or equal to the count of the previous event.
- R8: In mode 6 (local extremum), every event stores the count. The flag is the OR of the R6 and R7 conditions.
- R9: In modes 4 to 6, the comparison uses an internal copy of the previous event's count. A preload does not alter that copy. The first event after reset, or the first event in the cycle where the mode value changes, never raises the flag.
- R10: A preload write puts the written value into the register one cycle later. If an event arrives in the same cycle as a preload, the preload wins and the event is discarded. A discarded event causes no flag and no update of the internal copy.
- R11: In mode 0 and mode 7, events are ignored: the register is unchanged and no flag rises.
- R12: The flag is high only in the cycle after a qualifying event. With no event, the flag is low in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| count | input | CNT_W | Timer count value |
| fault_evt | input | 1 | Fault event pulse |
| mode | input | 3 | Capture mode, 0 to 7 |
| pre_we | input | 1 | Preload write strobe |
| pre_data | input | CNT_W | Preload value |
| top_val | input | CNT_W | Counter top value |
| cap_val | output | CNT_W | Capture register |
| flag | output | 1 | One-cycle notification pulse |

## Verification
A software preload and a fault event can land in the same cycle. Both want to write the capture register, and the event also wants to advance the previous-sample history. The bench raises both strobes together in plain-capture mode and in local-minimum mode. It checks that the register takes the preload value and that no flag appears. It then sends two more local-minimum events whose expected flags differ depending on whether the discarded count entered the history.

// File: rtl/fcap_pkg.sv
package fcap_pkg;
  typedef enum logic [2:0] {
    M_OFF  = 3'd0,
    M_CAPT = 3'd1,
    M_RMIN = 3'd2,
    M_RMAX = 3'd3,
    M_LMIN = 3'd4,
    M_LMAX = 3'd5,
    M_LEXT = 3'd6,
    M_RSV  = 3'd7
  } fcap_mode_e;
endpackage

// File: rtl/fcap_decide.sv
module fcap_decide
  import fcap_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic [2:0]       mode,
  input  logic             fault_evt,
  input  logic             pre_we,
  input  logic [CNT_W-1:0] count,
  input  logic [CNT_W-1:0] cap_q,
  input  logic [CNT_W-1:0] top_val,
  input  logic [CNT_W-1:0] prev_q,
  input  logic             prev_ok,
  output logic             take,
  output logic             hit,
  output logic             take_local
);
  logic live;
  logic below_cap, above_cap, ge_prev, le_prev;
  logic min_armed, max_armed;

  // A preload in the same cycle discards the event (R10)
  assign live      = fault_evt & ~pre_we;
  assign below_cap = count < cap_q;
  assign above_cap = count > cap_q;
  assign ge_prev   = count >= prev_q;
  assign le_prev   = count <= prev_q;
  assign min_armed = cap_q != '0;
  assign max_armed = cap_q != top_val;

  always_comb begin
    take       = 1'b0;
    hit        = 1'b0;
    take_local = 1'b0;
    unique case (fcap_mode_e'(mode))
      M_CAPT: begin
        take = live;
        hit  = live;
      end
      M_RMIN: begin
        take = live & min_armed & below_cap;
        hit  = take;
      end
      M_RMAX: begin
        take = live & max_armed & above_cap;
        hit  = take;
      end
      M_LMIN: begin
        take       = live;
        take_local = live;
        hit        = live & prev_ok & ge_prev;
      end
      M_LMAX: begin
        take       = live;
        take_local = live;
        hit        = live & prev_ok & le_prev;
      end
      M_LEXT: begin
        take       = live;
        take_local = live;
        hit        = live & prev_ok & (ge_prev | le_prev);
      end
      default: begin
        take = 1'b0;
        hit  = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/fcap_hist.sv
module fcap_hist #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       mode,
  input  logic             take_local,
  input  logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] prev_q,
  output logic             prev_ok
);
  logic [2:0] mode_q;
  logic       have_q;
  logic       mode_moved;

  assign mode_moved = mode != mode_q;
  assign prev_ok    = have_q & ~mode_moved;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= '0;
      have_q <= 1'b0;
      prev_q <= '0;
    end else begin
      mode_q <= mode;
      if (take_local) begin
        prev_q <= count;
        have_q <= 1'b1;
      end else if (mode_moved) begin
        have_q <= 1'b0;
      end
    end
  end

  // R9: history copy follows each taken local-mode event
  a_r9_history_follows: assert property (@(posedge clk) disable iff (!rst_n)
    take_local |=> (prev_q == $past(count)) && have_q);

  // R9: a mode change with no event empties the history
  a_r9_mode_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_moved && !take_local) |=> !have_q);
endmodule

// File: rtl/fault_capture_unit.sv
module fault_capture_unit #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] count,
  input  logic             fault_evt,
  input  logic [2:0]       mode,
  input  logic             pre_we,
  input  logic [CNT_W-1:0] pre_data,
  input  logic [CNT_W-1:0] top_val,
  output logic [CNT_W-1:0] cap_val,
  output logic             flag
);
  logic [CNT_W-1:0] cap_q;
  logic [CNT_W-1:0] prev_q;
  logic             prev_ok;
  logic             take, hit, take_local;
  logic             flag_q;

  fcap_decide #(.CNT_W(CNT_W)) u_decide (
    .mode       (mode),
    .fault_evt  (fault_evt),
    .pre_we     (pre_we),
    .count      (count),
    .cap_q      (cap_q),
    .top_val    (top_val),
    .prev_q     (prev_q),
    .prev_ok    (prev_ok),
    .take       (take),
    .hit        (hit),
    .take_local (take_local)
  );

  fcap_hist #(.CNT_W(CNT_W)) u_hist (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode       (mode),
    .take_local (take_local),
    .count      (count),
    .prev_q     (prev_q),
    .prev_ok    (prev_ok)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      if (pre_we)    cap_q <= pre_data;
      else if (take) cap_q <= count;
      flag_q <= hit;
    end
  end

  assign cap_val = cap_q;
  assign flag    = flag_q;

  // R2: plain capture stores and flags
  a_r2_plain_store: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_evt && !pre_we && mode == 3'd1) |=> (cap_val == $past(count)) && flag);

  // R3: running minimum never rises without a preload
  a_r3_min_no_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd2 && !pre_we) |=> cap_val <= $past(cap_val));

  // R4: running maximum never falls without a preload
  a_r4_max_no_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd3 && !pre_we) |=> cap_val >= $past(cap_val));

  // R5: disabled running maximum holds
  a_r5_max_parked: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd3 && !pre_we && cap_val == top_val) |=> $stable(cap_val) && !flag);

  // R9: first local event after a mode change is silent
  a_r9_first_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != $past(mode) && mode >= 3'd4 && mode <= 3'd6) |=> !flag);

  // R10: preload wins and silences the flag
  a_r10_preload_wins: assert property (@(posedge clk) disable iff (!rst_n)
    pre_we |=> (cap_val == $past(pre_data)) && !flag);

  // R11: idle modes ignore events
  a_r11_idle_modes: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd0 || mode == 3'd7) && !pre_we |=> $stable(cap_val) && !flag);

  // R12: no event, no flag next cycle
  a_r12_flag_needs_event: assert property (@(posedge clk) disable iff (!rst_n)
    !fault_evt |=> !flag);
endmodule

// File: tb/sim_fault_capture_unit.sv
`timescale 1ns/1ps
module sim_fault_capture_unit;
  localparam int W  = 16;
  localparam int NV = 34;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [W-1:0] count, pre_data, top_val;
  logic         fault_evt, pre_we;
  logic [2:0]   mode;
  logic [W-1:0] cap_val;
  logic         flag;
  int           n_chk = 0;
  int           n_err = 0;

  always #2.5 clk = ~clk;

  fault_capture_unit #(.CNT_W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .count(count), .fault_evt(fault_evt),
    .mode(mode), .pre_we(pre_we), .pre_data(pre_data), .top_val(top_val),
    .cap_val(cap_val), .flag(flag)
  );

  // Vector tags: 0-1 R2, 2 R12, 3 R10, 4-6 R3, 7 R10, 8-9 R4, 10 R10, 11 R5,
  // 12 R10, 13 R5, 14 R9, 15-17 R6, 18 R9, 19-20 R7, 21 R10, 22 R9, 23 R9,
  // 24-25 R8, 26-27 R11, 28 R10, 29 R2, 30 R9, 31-32 R10, 33 R6
  localparam logic [2:0] V_MODE [NV] = '{
    1,1,1,2,2,2,2,3,3,3,3,3,2,2,4,4,4,4,5,5,5,5,5,6,6,6,0,7,1,1,4,4,4,4};
  localparam logic V_PRE [NV] = '{
    0,0,0,1,0,0,0,1,0,0,1,0,1,0,0,0,0,0,0,0,0,1,0,0,0,0,0,0,1,0,0,1,0,0};
  localparam logic V_EVT [NV] = '{
    1,1,0,0,1,1,1,0,1,1,0,1,0,1,1,1,1,1,1,1,1,0,1,1,1,1,1,1,1,1,1,1,1,1};
  localparam logic [W-1:0] V_CNT [NV] = '{
    10,5,7,0,50,60,20,0,40,35,0,511,0,3,20,10,15,15,12,8,9,0,9,30,31,2,77,78,
    300,301,50,10,40,45};
  localparam logic [W-1:0] V_PD [NV] = '{
    0,0,0,100,0,0,0,30,0,0,240,0,0,0,0,0,0,0,0,0,0,500,0,0,0,0,0,0,
    400,0,0,99,0,0};
  localparam logic [W-1:0] V_CAP [NV] = '{
    10,5,5,100,50,50,20,30,40,40,240,240,0,0,20,10,15,15,12,8,9,500,9,30,31,2,
    2,2,400,301,50,99,40,45};
  localparam logic V_FLG [NV] = '{
    1,1,0,0,1,0,1,0,1,0,0,0,0,0,0,0,1,1,0,1,0,0,1,0,1,1,0,0,0,1,0,0,0,1};
  localparam int V_REQ [NV] = '{
    2,2,12,10,3,3,3,10,4,4,10,5,10,5,9,6,6,6,9,7,7,10,9,9,8,8,11,11,10,2,9,10,10,6};

  task automatic check(input string req, input logic [W-1:0] ecap, input logic ef);
    n_chk++;
    if (cap_val !== ecap || flag !== ef) begin
      n_err++;
      $display("FAIL %s: cap=%0d flag=%0b expected cap=%0d flag=%0b",
               req, cap_val, flag, ecap, ef);
    end
  endtask

  task automatic step(input logic [2:0] m, input logic pw, input logic ev,
                      input logic [W-1:0] c, input logic [W-1:0] pd);
    mode = m; pre_we = pw; fault_evt = ev; count = c; pre_data = pd;
    @(negedge clk);
    fault_evt = 1'b0; pre_we = 1'b0;
  endtask

  initial begin
    #(5.0 * 200000);
    n_err++;
    $display("FAIL watchdog: run did not complete");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; fault_evt = 1'b0; pre_we = 1'b0; mode = 3'd0;
    count = '0; pre_data = '0; top_val = 16'd240;
    repeat (3) @(negedge clk);
    check("R1", 16'd0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", 16'd0, 1'b0);

    for (int i = 0; i < NV; i++) begin
      step(V_MODE[i], V_PRE[i], V_EVT[i], V_CNT[i], V_PD[i]);
      check($sformatf("R%0d vec%0d", V_REQ[i], i), V_CAP[i], V_FLG[i]);
    end

    // R1: reset mid-run clears register and flag
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 midrun", 16'd0, 1'b0);
    rst_n = 1'b1;
    // R9: first local event after reset is silent
    step(3'd4, 1'b0, 1'b1, 16'd60, 16'd0);
    check("R9 after reset", 16'd60, 1'b0);
    // R6: rising sample flags
    step(3'd4, 1'b0, 1'b1, 16'd70, 16'd0);
    check("R6 rise", 16'd70, 1'b1);
    // R12: flag drops when no event follows
    step(3'd4, 1'b0, 1'b0, 16'd80, 16'd0);
    check("R12 single pulse", 16'd70, 1'b0);
    // R5: parked maximum with count above top
    step(3'd3, 1'b1, 1'b0, 16'd0, 16'd240);
    step(3'd3, 1'b0, 1'b1, 16'd1000, 16'd0);
    check("R5 max parked", 16'd240, 1'b0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule